// File: doc/BRIEF.md
# Boot Watchdog with Boot-Device Failover

This block supervises the power-up of a board from the power controller's side. It holds the board's primary-supply enable. When a countdown runs out it cuts that enable for a short interval and then restores it, so the whole board is power-cycled rather than reset. Two countdowns share the expiry path. The first is a general watchdog that host software enables and kicks. The second is a boot countdown that is armed at every power-up and that, on expiry, also flips the boot-device select. A recovery image on the alternate device can then be tried on the next boot.

Timing runs off a prescaled tick strobe, nominally 1 Hz, and a parameter scales seconds to ticks. Software reaches three byte registers through a plain write/read port: control, interrupt status and interrupt enable. The boot select, the timeout flag and the registers all sit in the always-powered domain. They are cleared only by `rst_n`, which models loss of the backup supply, and never by the power cycle that the block itself drives. The timeout flag can therefore be read after power-on as the cause of the restart.

Top module: `boot_supervisor`

## Requirements
- R1: After `rst_n` the supply enable is 1, the boot select is 0, the interrupt output is 0 and all three registers (address 0 control, 1 status, 2 enable) read 0.
- R2: Writing control with bit 5 = 1 arms the general countdown. It expires on the 30·TPS-th tick after the write if control bit 4 = 0, or on the 60·TPS-th tick if bit 4 = 1. The supply enable drops in the cycle that registers that tick. Clock cycles without a tick do not advance any countdown.
- R3: Every control write with bit 5 = 1 restarts the general countdown from its full length. A control write with bit 5 = 0 stops it.
- R4: After an expiry the supply enable stays 0 for exactly OFF_TICKS ticks and returns to 1 with the last of them. No countdown advances while the supply is off.
- R5: At each return of the supply, the general countdown re-arms by itself if control bit 5 is set.
- R6: Control bit 6 arms a boot countdown of BOOT_SEC·TPS ticks, but only at a power-up, not at the write itself. Its expiry power-cycles the board and inverts `boot_alt` exactly once. A general-countdown expiry leaves `boot_alt` unchanged.
- R7: Writing 1 to control bit 7 stops the boot countdown for the current boot. The bit reads back as 1 until the next power-up, which clears it, and writing 0 to it has no effect. The boot countdown re-arms at that power-up if bit 6 is still set.
- R8: Status bit 6 (address 1) is set by every expiry. It stays set through the power cycle, is cleared by writing 1 to it, and is unaffected by writing 0 to it.
- R9: `irq` is 1 exactly when status bit 6 and enable bit 6 (address 2) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset of the always-on domain |
| tick | input | 1 | One-cycle strobe, TICKS_PER_SEC per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| supply_en | output | 1 | Primary-supply enable of the board |
| boot_alt | output | 1 | Boot-device select, 1 = alternate |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with TICKS_PER_SEC = 2, general windows of 3 s and 5 s, a 4 s boot window and OFF_TICKS = 3. That gives countdowns of 6, 10 and 8 ticks and an off interval of 3 ticks. These lengths are short enough to check the supply enable after every single tick of each window. They also allow a kick at every possible offset inside the short window. Repeated power cycles are then cheap, so the bench can step through the boot select toggling once per boot expiry, the one-boot suppression by bit 7 and its re-arming, and the timeout flag persisting across cycles.

// File: rtl/boot_sup_pkg.sv
// Package: register addresses and bit positions shared by the supervisor.
// Assumes a 2-bit register address space with byte-wide registers.
package boot_sup_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_IEN  = 2'd2;

    localparam int BIT_LONG  = 4;  // general timeout length select
    localparam int BIT_WDEN  = 5;  // general countdown enable / kick
    localparam int BIT_FOEN  = 6;  // boot failover enable
    localparam int BIT_FOCLR = 7;  // boot countdown cancel for this boot
    localparam int BIT_TOUT  = 6;  // timeout flag in status and enable
endpackage

// File: rtl/bsup_countdown.sv
// Module: loadable tick countdown with a one-cycle expiry strobe.
// Assumes load_val is never zero. Load has priority over stop. The counter
// only moves on a tick while run is high.
module bsup_countdown #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         stop,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic         act_q;

    assign expire = act_q & run & tick & (cnt_q == W'(1)) & ~load & ~stop;

    // Counter: load, cancel, or count down one step per qualified tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            act_q <= 1'b1;
            cnt_q <= load_val;
        end else if (stop) begin
            act_q <= 1'b0;
        end else if (act_q && run && tick) begin
            if (cnt_q == W'(1)) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));
    assert_active_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (cnt_q != '0));
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !stop) |=> $stable(cnt_q));
endmodule

// File: rtl/bsup_power_seq.sv
// Module: supply sequencer. Drops the supply enable on an expiry and holds
// it low for OFF_T ticks, then raises it with a one-cycle power-up strobe.
// Assumes expiry only arrives while the supply is on.
module bsup_power_seq #(
    parameter int OFF_T = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic expire,
    output logic supply_en,
    output logic power_up
);
    localparam int OW = $clog2(OFF_T + 1);

    logic          on_q;
    logic [OW-1:0] off_q;

    assign supply_en = on_q;
    assign power_up  = ~on_q & tick & (off_q == OW'(1));

    // Sequencer: on -> off on expiry, off -> on after OFF_T ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q  <= 1'b1;
            off_q <= '0;
        end else if (on_q && expire) begin
            on_q  <= 1'b0;
            off_q <= OW'(OFF_T);
        end else if (!on_q && tick) begin
            if (off_q == OW'(1)) begin
                on_q  <= 1'b1;
                off_q <= '0;
            end else begin
                off_q <= off_q - 1'b1;
            end
        end
    end

    assert_off_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !on_q |-> (off_q != '0 && off_q <= OW'(OFF_T)));
    assert_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_q && !tick) |=> !on_q);
endmodule

// File: rtl/boot_supervisor.sv
// Module: boot watchdog top. Holds the registers, the two countdowns, the
// supply sequencer and the boot select. All state is in the always-on domain
// and is cleared only by rst_n. Assumes tick is a single-cycle strobe.
module boot_supervisor
    import boot_sup_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1,
    parameter int WD_SHORT_SEC  = 30,
    parameter int WD_LONG_SEC   = 60,
    parameter int BOOT_SEC      = 30,
    parameter int OFF_TICKS     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       supply_en,
    output logic       boot_alt,
    output logic       irq
);
    localparam int SHORT_T = WD_SHORT_SEC * TICKS_PER_SEC;
    localparam int LONG_T  = WD_LONG_SEC * TICKS_PER_SEC;
    localparam int BOOT_T  = BOOT_SEC * TICKS_PER_SEC;
    localparam int WD_W    = $clog2(LONG_T + 1);
    localparam int BT_W    = $clog2(BOOT_T + 1);
    localparam logic [WD_W-1:0] SHORT_LD = WD_W'(SHORT_T);
    localparam logic [WD_W-1:0] LONG_LD  = WD_W'(LONG_T);
    localparam logic [BT_W-1:0] BOOT_LD  = BT_W'(BOOT_T);

    logic long_q, wden_q, foen_q, foclr_q, tout_q, ien_q, alt_q;
    logic wr_ctrl, wr_stat, wr_ien;
    logic power_up, wd_exp, bt_exp;
    logic wd_load, wd_stop, wd_long_sel, bt_load, bt_stop;
    logic [WD_W-1:0] wd_len;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[3:0];
    assign wr_ctrl = reg_wr & (reg_addr == ADDR_CTRL);
    assign wr_stat = reg_wr & (reg_addr == ADDR_STAT);
    assign wr_ien  = reg_wr & (reg_addr == ADDR_IEN);

    assign wd_load     = (wr_ctrl & reg_wdata[BIT_WDEN]) | (power_up & wden_q & ~wr_ctrl);
    assign wd_stop     = wr_ctrl & ~reg_wdata[BIT_WDEN];
    assign wd_long_sel = wr_ctrl ? reg_wdata[BIT_LONG] : long_q;
    assign wd_len      = wd_long_sel ? LONG_LD : SHORT_LD;
    assign bt_load     = power_up & foen_q;
    assign bt_stop     = foclr_q | (wr_ctrl & reg_wdata[BIT_FOCLR]);

    bsup_countdown #(.W(WD_W)) u_wd_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(supply_en),
        .load(wd_load), .load_val(wd_len), .stop(wd_stop), .expire(wd_exp)
    );

    bsup_countdown #(.W(BT_W)) u_boot_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(supply_en),
        .load(bt_load), .load_val(BOOT_LD), .stop(bt_stop), .expire(bt_exp)
    );

    bsup_power_seq #(.OFF_T(OFF_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .expire(wd_exp | bt_exp),
        .supply_en(supply_en), .power_up(power_up)
    );

    // Control register: plain bits, sticky cancel bit cleared at power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_q  <= 1'b0;
            wden_q  <= 1'b0;
            foen_q  <= 1'b0;
            foclr_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                long_q  <= reg_wdata[BIT_LONG];
                wden_q  <= reg_wdata[BIT_WDEN];
                foen_q  <= reg_wdata[BIT_FOEN];
                foclr_q <= foclr_q | reg_wdata[BIT_FOCLR];
            end
            if (power_up) foclr_q <= 1'b0;
        end
    end

    // Timeout flag, interrupt enable and boot select in the retained domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout_q <= 1'b0;
            ien_q  <= 1'b0;
            alt_q  <= 1'b0;
        end else begin
            if (wd_exp || bt_exp)                   tout_q <= 1'b1;
            else if (wr_stat && reg_wdata[BIT_TOUT]) tout_q <= 1'b0;
            if (wr_ien)  ien_q <= reg_wdata[BIT_TOUT];
            if (bt_exp)  alt_q <= ~alt_q;
        end
    end

    // Read mux for the three registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {foclr_q, foen_q, wden_q, long_q, 4'b0};
            ADDR_STAT: reg_rdata[BIT_TOUT] = tout_q;
            ADDR_IEN:  reg_rdata[BIT_TOUT] = ien_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign boot_alt = alt_q;
    assign irq      = tout_q & ien_q;

    assert_alt_on_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alt_q) |-> $fell(supply_en));
    assert_flag_on_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> tout_q);
    assert_cancel_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_en) |-> !foclr_q);
endmodule

// File: tb/test_boot_supervisor.sv
// Bench: small windows (6/10/8 ticks, off 3) swept tick by tick.
module test_boot_supervisor;
    localparam int TPS = 2, SS = 3, LS = 5, BSEC = 4, OFF = 3;
    localparam int ST = SS * TPS, LT = LS * TPS, BT = BSEC * TPS;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       supply_en, boot_alt, irq;
    int nvec = 0, nbad = 0;
    logic [7:0] v;

    boot_supervisor #(.TICKS_PER_SEC(TPS), .WD_SHORT_SEC(SS), .WD_LONG_SEC(LS),
                      .BOOT_SEC(BSEC), .OFF_TICKS(OFF)) i_boot_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .supply_en(supply_en),
        .boot_alt(boot_alt), .irq(irq));

    always #10 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tk();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
        @(negedge clk) reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Expect expiry on exactly the len-th tick.
    task automatic sweep(int len, string req);
        for (int i = 1; i <= len; i++) begin
            tk();
            chk(req, supply_en, (i < len) ? 1 : 0);
        end
    endtask

    task automatic off_phase();
        for (int i = 1; i <= OFF; i++) begin
            tk();
            chk("R4", supply_en, (i == OFF) ? 1 : 0);
        end
    endtask

    task automatic quiet(int n, string req);
        for (int i = 0; i < n; i++) begin
            tk();
            chk(req, supply_en, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", supply_en, 1); chk("R1", boot_alt, 0); chk("R1", irq, 0);
        for (int a = 0; a < 3; a++) begin rd(a[1:0], v); chk("R1", v, 0); end
        quiet(30, "R2");

        // R2 short window, R8 flag, R5 re-arm, R6 no toggle on general expiry
        wr(0, 8'h20); rd(0, v); chk("R2", v, 8'h20);
        sweep(ST, "R2");
        chk("R6", boot_alt, 0);
        rd(1, v); chk("R8", v, 8'h40);
        off_phase();
        sweep(ST, "R5");
        off_phase();
        wr(0, 8'h00); wr(1, 8'h40);

        // R2 long window; R3 disable after re-arm
        wr(0, 8'h30);
        sweep(LT, "R2");
        off_phase();
        wr(0, 8'h00);
        quiet(LT + 2, "R3");

        // R3 kick at every offset
        for (int k = 1; k < ST; k++) begin
            wr(0, 8'h20);
            quiet(k, "R3");
            wr(0, 8'h20);
            sweep(ST, "R3");
            off_phase();
            wr(0, 8'h00);
        end
        // R2 idle cycles without tick do not advance
        wr(0, 8'h20);
        repeat (50) @(negedge clk);
        sweep(ST, "R2");
        off_phase();
        wr(0, 8'h00);
        wr(1, 8'h40); rd(1, v); chk("R8", v, 0);

        // R8 persistence and clearing, R9 gating
        wr(0, 8'h20);
        sweep(ST, "R8");
        rd(1, v); chk("R8", v, 8'h40);
        off_phase();
        wr(0, 8'h00);
        rd(1, v); chk("R8", v, 8'h40);
        chk("R9", irq, 0);
        wr(2, 8'h40); rd(2, v); chk("R9", v, 8'h40); chk("R9", irq, 1);
        wr(1, 8'h00); rd(1, v); chk("R8", v, 8'h40); chk("R9", irq, 1);
        wr(1, 8'h40); rd(1, v); chk("R8", v, 0); chk("R9", irq, 0);
        wr(2, 8'h00);

        // R6 boot countdown armed only at power-up
        wr(0, 8'h40);
        quiet(2 * BT, "R6");
        wr(0, 8'h60);
        sweep(ST, "R2");
        chk("R6", boot_alt, 0);
        off_phase();
        wr(0, 8'h40);
        sweep(BT, "R6");
        chk("R6", boot_alt, 1);
        off_phase();
        chk("R6", boot_alt, 1);
        // R7 cancel for this boot only
        wr(0, 8'hC0); rd(0, v); chk("R7", v, 8'hC0);
        quiet(2 * BT, "R7");
        chk("R7", boot_alt, 1);
        wr(0, 8'h40); rd(0, v); chk("R7", v, 8'hC0);
        wr(0, 8'hE0);
        sweep(ST, "R2");
        chk("R7", boot_alt, 1);
        off_phase();
        rd(0, v); chk("R7", v, 8'h60);
        wr(0, 8'h40);
        sweep(BT, "R7");
        chk("R6", boot_alt, 0);
        off_phase();
        wr(0, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule